// File: doc/BRIEF.md
# Alternating-Polarity Ripple-Carry Adder

A combinational N-bit adder that forms `a + b + carry_in` through a linear chain of full-adder cells. Each cell is modelled as an inverting full adder: it returns the complement of both the sum and the carry. Complementing all three inputs of a full adder complements both of its outputs. The chain uses this identity so that the link between neighbouring cells never needs an inverter.

Cells at even bit positions take true operands and a true incoming carry. They pass an inverted carry to the next bit. Cells at odd bit positions complement their two operand bits and accept the inverted carry unchanged. Their carry output is then true again. Each sum bit leaves the block in true polarity. The carry from the last cell is complemented only when the width is odd, so the outgoing carry is always true.

Delay grows linearly with the width: (N−1) carry-link delays plus one sum delay. The block suits a datapath where area matters more than speed, or where it serves as a baseline for faster carry schemes.

Top module: `alt_ripple_adder`

## Requirements
- R1: For every input combination at WIDTH=16, `{carry_o, sum_o}` equals `a_i + b_i + carry_i` taken as unsigned integers.
- R2: When every bit position propagates (a_i XOR b_i all ones), carry_o equals carry_i. In that case sum_o is all zeros when carry_i is 1 and all ones when carry_i is 0.
- R3: A cell at an even bit position whose two operand bits are both 1 drives its outgoing link low, which is an inverted carry of 1. When both bits are 0, it drives the link high.
- R4: A cell at an odd bit position whose two operand bits are both 1 drives its outgoing link high, which is a true carry of 1. When both bits are 0, it drives the link low.
- R5: At odd WIDTH (17), carry_o is in true polarity and equals bit WIDTH of the full sum.
- R6: At WIDTH=4, the result is correct for all 512 combinations of a_i, b_i and carry_i.
- R7: All-zero inputs give sum_o = 0 and carry_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| carry_i | input | 1 | Incoming carry, true polarity |
| sum_o | output | WIDTH | Sum bits, true polarity |
| carry_o | output | 1 | Outgoing carry, true polarity |

## Verification
Within one evaluation, a carry generated at one cell can meet a carry that is propagating through it. The two cell types handle that carry in opposite polarities. Generate patterns placed only on even bits (0x5555) and only on odd bits (0xAAAA) provoke this case. So does a long propagate run fed by carry_i, at both an even and an odd width. Each result is judged against an unsigned integer sum computed in the bench, and the whole space is swept at WIDTH=4.

// File: rtl/alt_ripple_adder.sv
module alt_ripple_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  // link[k]: true polarity at even k, inverted at odd k
  logic [WIDTH:0] link;
  assign link[0] = carry_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_cell
    logic x, y, z, s_n, c_n;

    // inverting full adder: complement of sum and of majority
    assign s_n = ~(x ^ y ^ z);
    assign c_n = ~((x & y) | (y & z) | (x & z));

    if (k % 2 == 0) begin : g_even
      assign x = a_i[k];
      assign y = b_i[k];
      assign z = link[k];
      assign sum_o[k]  = ~s_n;
      assign link[k+1] = c_n;

      always_comb begin
        if (a_i[k] && b_i[k])
          a_r3_even_generate: assert (link[k+1] == 1'b0) else $error("R3 even generate");
        if (!a_i[k] && !b_i[k])
          a_r3_even_kill: assert (link[k+1] == 1'b1) else $error("R3 even kill");
      end
    end else begin : g_odd
      assign x = ~a_i[k];
      assign y = ~b_i[k];
      assign z = link[k];
      assign sum_o[k]  = s_n;
      assign link[k+1] = c_n;

      always_comb begin
        if (a_i[k] && b_i[k])
          a_r4_odd_generate: assert (link[k+1] == 1'b1) else $error("R4 odd generate");
        if (!a_i[k] && !b_i[k])
          a_r4_odd_kill: assert (link[k+1] == 1'b0) else $error("R4 odd kill");
      end
    end
  end

  if (WIDTH % 2 == 1) begin : g_out_odd
    assign carry_o = ~link[WIDTH];
  end else begin : g_out_even
    assign carry_o = link[WIDTH];
  end

  logic [WIDTH:0] total;
  assign total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};

  always_comb begin
    a_r1_total: assert ({carry_o, sum_o} == total) else $error("R1 total mismatch");
    a_r5_carry_true: assert (carry_o == total[WIDTH]) else $error("R5 carry polarity");
    if ((a_i ^ b_i) == {WIDTH{1'b1}})
      a_r2_full_propagate: assert (carry_o == carry_i && sum_o == {WIDTH{~carry_i}})
        else $error("R2 propagate run");
  end

endmodule

// File: tb/test_alt_ripple_adder.sv
module test_alt_ripple_adder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  logic [3:0]  a4, b4, s4;
  logic        c4, co4;
  logic [16:0] a17, b17, s17;
  logic        c17, co17;

  alt_ripple_adder #(.WIDTH(16)) i_alt_ripple_adder (
    .a_i(a16), .b_i(b16), .carry_i(c16), .sum_o(s16), .carry_o(co16));
  alt_ripple_adder #(.WIDTH(4)) i_alt_ripple_adder_w4 (
    .a_i(a4), .b_i(b4), .carry_i(c4), .sum_o(s4), .carry_o(co4));
  alt_ripple_adder #(.WIDTH(17)) i_alt_ripple_adder_w17 (
    .a_i(a17), .b_i(b17), .carry_i(c17), .sum_o(s17), .carry_o(co17));

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [17:0] model(input logic [16:0] a, input logic [16:0] b, input logic c);
    return 18'(a) + 18'(b) + 18'(c);
  endfunction

  task automatic step(input logic [15:0] xa16, input logic [15:0] xb16, input logic xc16,
                      input logic [16:0] xa17, input logic [16:0] xb17, input logic xc17,
                      input string req);
    @(posedge clk);
    a16 = xa16; b16 = xb16; c16 = xc16;
    a17 = xa17; b17 = xb17; c17 = xc17;
    @(negedge clk);
    chk({req, " w16"}, {1'b0, co16, s16}, model({1'b0, xa16}, {1'b0, xb16}, xc16));
    chk({req, " w17"}, {co17, s17}, model(xa17, xb17, xc17));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    a16 = '0; b16 = '0; c16 = 1'b0;
    a4 = '0; b4 = '0; c4 = 1'b0;
    a17 = '0; b17 = '0; c17 = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: zero inputs
    chk("R7 zero w16", {1'b0, co16, s16}, 18'd0);
    chk("R7 zero w17", {co17, s17}, 18'd0);
    chk("R7 zero w4", {13'd0, co4, s4}, 18'd0);

    // R2: full propagate, both carry values
    step(16'hFFFF, 16'h0000, 1'b1, 17'h1FFFF, 17'h00000, 1'b1, "R2 propagate cin1");
    step(16'hF0F0, 16'h0F0F, 1'b0, 17'h0F0F0, 17'h10F0F, 1'b0, "R2 propagate cin0");
    step(16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, 17'h1FFFF, 1'b1, "R1 all ones");
    // R3: generate only on even bits
    step(16'h5555, 16'h5555, 1'b0, 17'h15555, 17'h15555, 1'b0, "R3 even generate");
    step(16'h5555, 16'h0000, 1'b1, 17'h15555, 17'h00000, 1'b1, "R3 even mixed");
    // R4: generate only on odd bits
    step(16'hAAAA, 16'hAAAA, 1'b0, 17'h0AAAA, 17'h0AAAA, 1'b0, "R4 odd generate");
    step(16'hAAAA, 16'h5555, 1'b1, 17'h0AAAA, 17'h15555, 1'b1, "R4 odd propagate");
    // R5: carry out of the last (even-index) cell at odd width
    step(16'h8000, 16'h8000, 1'b0, 17'h10000, 17'h10000, 1'b0, "R5 top generate");
    step(16'h0001, 16'hFFFF, 1'b0, 17'h00001, 17'h1FFFF, 1'b0, "R5 long ripple");

    // R6: exhaustive at width 4
    for (int v = 0; v < 512; v++) begin
      @(posedge clk);
      a4 = v[3:0]; b4 = v[7:4]; c4 = v[8];
      @(negedge clk);
      chk("R6 exhaustive w4", {13'd0, co4, s4},
          model({13'd0, v[3:0]}, {13'd0, v[7:4]}, v[8]));
    end

    // R1 and R5: random vectors
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r0, r1, r2;
      r0 = $urandom; r1 = $urandom; r2 = $urandom;
      step(r0[15:0], r1[15:0], r2[0], {r2[1], r0[31:16]}, {r2[2], r1[31:16]}, r2[3],
           "R1 R5 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule